// File: doc/BRIEF.md
# Packed Bitmap Row Scanner

This block turns a one-bit-per-pixel bitmap held in a byte-wide RAM into a colour code per pixel for a raster display. The visible picture is 128 pixels wide and is built from 7 text lines. Each text line is 7 pixel rows tall, so 49 stored rows are shown. Each stored byte covers 8 neighbouring pixels. A set bit shows the foreground colour and a clear bit shows the background colour.

The stored rows sit back to back in memory, with nothing between text lines. The scanner adds the blank spacing rows between text lines on its own, without fetching them. The number of spacing rows is a parameter and is 1 by default. Memory used for empty rows is therefore zero.

A timing generator outside the block supplies three signals: a pixel-clock enable, a strobe at the start of each raster row and a strobe at the start of each frame. The scanner issues each byte read one enable ahead of the byte's first pixel, which hides one cycle of RAM latency. The address of the first stored byte is held in a writable base register. Its reset value is 0x0C2F.

Top module: `packed_row_scanner`

## Requirements
- R1: After reset, `pix_out` equals `bg_color`, `mem_rd` is low, the base register holds 0x0C2F, and the scan position is row 0 of text line 0.
- R2: A `line_start` pulse arms one raster row. The first `pix_en` cycle after it issues the byte-0 read and leaves `pix_out` at background. Pixel p (0..127) appears on `pix_out` after the clock edge of the (p+2)-th `pix_en` cycle, and it holds while `pix_en` is low.
- R3: Bit 7 of each byte is the leftmost of its 8 pixels. A 1 bit shows `fg_color` and a 0 bit shows `bg_color`.
- R4: A bitmap row makes exactly 16 reads, at row address +0 through +15, in that order. Byte 0 is read on the 1st `pix_en` after `line_start`. Byte j (1..15) is read on the (8j+1)-th `pix_en`, one enable before its first pixel.
- R5: Stored row n (0..48) starts at base + 16·n, taken modulo 2^16, with no gap between text lines. The scan position advances on the `pix_en` edge that shows pixel 127.
- R6: After the 7th row of each text line, GAP_ROWS raster rows (default 1) show only background. These rows make no reads and do not advance the RAM address.
- R7: After the 7th text line and its spacing rows, every raster row is background with no reads until the next `frame_start`.
- R8: Before pixel 0 of a row and after pixel 127, until the next `line_start`, `pix_out` is background and no read is issued.
- R9: A write (`base_we` high with `base_wdata`) changes the base register. The new value is used only from the next `frame_start`. Rows of the current frame keep their addresses.
- R10: `frame_start` returns the scan position to row 0 of text line 0, at the current base register value.
- R11: `mem_rd` is high only in cycles where `pix_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel-clock enable, one pixel per high cycle |
| line_start | input | 1 | Start-of-raster-row strobe |
| frame_start | input | 1 | Start-of-frame strobe |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | 16 | New base address |
| fg_color | input | 4 | Colour code for set bits |
| bg_color | input | 4 | Colour code for clear bits and blank areas |
| mem_rd | output | 1 | RAM read request; the address is sampled on this clock edge |
| mem_addr | output | 16 | RAM byte address |
| mem_data | input | 8 | RAM read data, valid after the read edge and held until the next read |
| pix_out | output | 4 | Colour code of the current pixel |

## Verification
A corrupt vertical counter shows up on the first raster row after it goes wrong. Reads start at the wrong row address, or they appear on a spacing row or after the last line, so the first read of that row exposes it. A wrong horizontal count or shifter state moves pixels sideways or changes the read timing within the same row. It becomes visible no later than the next byte boundary, which is at most 8 enables away. A base register that changes too early shows the wrong read address on the very next row.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_PRE  = 2'd1,
    H_ACT  = 2'd2
  } hstate_t;
endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/prs_hseq.sv
module prs_hseq
  import prs_pkg::*;
#(
  parameter int ACTIVE_PIX = 128,
  parameter int BYTE_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic line_start,
  input  logic row_fetch,
  output logic rd_req,
  output logic [$clog2(ACTIVE_PIX/BYTE_W)-1:0] rd_idx,
  output logic load_o,
  output logic row_end_o,
  output logic active_o
);
  localparam int PX_W  = $clog2(ACTIVE_PIX);
  localparam int SUB_W = $clog2(BYTE_W);
  localparam int IDX_W = $clog2(ACTIVE_PIX/BYTE_W);
  localparam logic [PX_W-1:0] LAST_PX = PX_W'(ACTIVE_PIX-1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BYTE_W-1);

  hstate_t st_q, st_n;
  logic [PX_W-1:0] px_q, px_n;
  logic in_act, at_last, at_sub_last;

  assign in_act      = (st_q == H_ACT);
  assign at_last     = (px_q == LAST_PX);
  assign at_sub_last = (px_q[SUB_W-1:0] == SUB_LAST);

  always_comb begin
    st_n = st_q;
    px_n = px_q;
    if (line_start) begin
      st_n = H_PRE;
      px_n = '0;
    end else if (pix_en) begin
      case (st_q)
        H_PRE: begin
          st_n = H_ACT;
          px_n = '0;
        end
        H_ACT: begin
          if (at_last) begin
            st_n = H_IDLE;
            px_n = '0;
          end else begin
            px_n = px_q + PX_W'(1);
          end
        end
        default: begin
          st_n = H_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= H_IDLE;
      px_q <= '0;
    end else begin
      st_q <= st_n;
      px_q <= px_n;
    end
  end

  assign rd_req    = pix_en && row_fetch &&
                     ((st_q == H_PRE) || (in_act && at_sub_last && !at_last));
  assign rd_idx    = (st_q == H_PRE) ? '0
                   : IDX_W'(px_q[PX_W-1:SUB_W]) + IDX_W'(1);
  assign load_o    = pix_en && in_act && (px_q[SUB_W-1:0] == '0);
  assign row_end_o = pix_en && in_act && at_last;
  assign active_o  = in_act;

  // R2: without an enable or a row strobe, the horizontal position stands still
  p_px_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !line_start) |=> ($stable(px_q) && $stable(st_q)));

  // R4: reads inside the window land only on the last pixel of a byte
  p_fetch_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && in_act) |-> (px_q[SUB_W-1:0] == SUB_LAST));

  // R2: the pre-fetch slot always leads into the active window
  p_pre_to_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == H_PRE && pix_en && !line_start) |=> (st_q == H_ACT && px_q == '0));
endmodule

// File: rtl/prs_vseq.sv
module prs_vseq #(
  parameter int ADDR_W        = 16,
  parameter int BYTES_PER_ROW = 16,
  parameter int ROWS_PER_LINE = 7,
  parameter int NUM_LINES     = 7,
  parameter int GAP_ROWS      = 1,
  parameter logic [ADDR_W-1:0] BASE_RST = 16'h0C2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              row_end,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              row_fetch_o
);
  localparam int RIN_W  = (ROWS_PER_LINE > 1) ? $clog2(ROWS_PER_LINE) : 1;
  localparam int LINE_W = $clog2(NUM_LINES + 1);
  localparam int GAP_W  = (GAP_ROWS > 1) ? $clog2(GAP_ROWS) : 1;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BYTES_PER_ROW);
  localparam logic [RIN_W-1:0]  RIN_LAST = RIN_W'(ROWS_PER_LINE - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(GAP_ROWS - 1);
  localparam logic [LINE_W-1:0] LINE_END = LINE_W'(NUM_LINES);
  localparam logic              HAS_GAP  = (GAP_ROWS > 0);

  logic [ADDR_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] row_addr_q, row_addr_n;
  logic [RIN_W-1:0]  rin_q, rin_n;
  logic [LINE_W-1:0] line_q, line_n;
  logic [GAP_W-1:0]  gcnt_q, gcnt_n;
  logic              in_gap_q, in_gap_n;
  logic              done;

  assign done = (line_q == LINE_END);

  always_comb begin
    base_n     = base_we ? base_wdata : base_q;
    row_addr_n = row_addr_q;
    rin_n      = rin_q;
    line_n     = line_q;
    gcnt_n     = gcnt_q;
    in_gap_n   = in_gap_q;
    if (frame_start) begin
      row_addr_n = base_q;
      rin_n      = '0;
      line_n     = '0;
      gcnt_n     = '0;
      in_gap_n   = 1'b0;
    end else if (row_end && !done) begin
      if (in_gap_q) begin
        if (gcnt_q == GAP_LAST) begin
          in_gap_n = 1'b0;
          gcnt_n   = '0;
        end else begin
          gcnt_n = gcnt_q + GAP_W'(1);
        end
      end else begin
        row_addr_n = row_addr_q + STEP;
        if (rin_q == RIN_LAST) begin
          rin_n    = '0;
          line_n   = line_q + LINE_W'(1);
          in_gap_n = HAS_GAP;
          gcnt_n   = '0;
        end else begin
          rin_n = rin_q + RIN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= BASE_RST;
      row_addr_q <= BASE_RST;
      rin_q      <= '0;
      line_q     <= '0;
      gcnt_q     <= '0;
      in_gap_q   <= 1'b0;
    end else begin
      base_q     <= base_n;
      row_addr_q <= row_addr_n;
      rin_q      <= rin_n;
      line_q     <= line_n;
      gcnt_q     <= gcnt_n;
      in_gap_q   <= in_gap_n;
    end
  end

  assign row_addr_o  = row_addr_q;
  assign row_fetch_o = !in_gap_q && !done;

  // R5: a finished bitmap row moves the address by exactly one stored row
  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && !done && !in_gap_q && !frame_start) |=>
      (row_addr_q == $past(row_addr_q) + STEP));

  // R5: the row-in-line counter stays within one text line
  p_rin_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rin_q <= RIN_LAST);

  // R6: spacing rows never move the RAM address
  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && in_gap_q && !frame_start) |=> (row_addr_q == $past(row_addr_q)));

  // R7: once all lines are shown, the address stays put until a new frame
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_start) |=> $stable(row_addr_q));

  // R10: a frame strobe restarts at the stored base, on a bitmap row
  p_frame_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ((row_addr_q == $past(base_q)) && (rin_q == '0) && row_fetch_o));
endmodule

// File: rtl/prs_shifter.sv
module prs_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              line_start,
  input  logic              active,
  input  logic              load,
  input  logic              row_fetch,
  input  logic [BYTE_W-1:0] mem_data,
  output logic              show_fg
);
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              fg_q, fg_n;

  always_comb begin
    sh_n = sh_q;
    fg_n = fg_q;
    if (line_start) begin
      fg_n = 1'b0;
      sh_n = '0;
    end else if (pix_en) begin
      if (active) begin
        if (load) begin
          fg_n = row_fetch && mem_data[BYTE_W-1];
          sh_n = row_fetch ? {mem_data[BYTE_W-2:0], 1'b0} : '0;
        end else begin
          fg_n = sh_q[BYTE_W-1];
          sh_n = {sh_q[BYTE_W-2:0], 1'b0};
        end
      end else begin
        fg_n = 1'b0;
        sh_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      fg_q <= 1'b0;
    end else begin
      sh_q <= sh_n;
      fg_q <= fg_n;
    end
  end

  assign show_fg = fg_q;

  // R8: an enable outside the active window always yields background
  p_blank_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !active && !line_start) |=> !show_fg);

  // R6: a non-bitmap row never lights a pixel on a byte load
  p_blank_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !row_fetch && !line_start) |=> !show_fg);
endmodule

// File: rtl/packed_row_scanner.sv
module packed_row_scanner #(
  parameter int ADDR_W        = 16,
  parameter int COLOR_W       = 4,
  parameter int BYTE_W        = 8,
  parameter int ACTIVE_PIX    = 128,
  parameter int ROWS_PER_LINE = 7,
  parameter int NUM_LINES     = 7,
  parameter int GAP_ROWS      = 1,
  parameter logic [ADDR_W-1:0] BASE_RST = 16'h0C2F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               line_start,
  input  logic               frame_start,
  input  logic               base_we,
  input  logic [ADDR_W-1:0]  base_wdata,
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0]  mem_data,
  output logic [COLOR_W-1:0] pix_out
);
  localparam int BYTES_PER_ROW = ACTIVE_PIX / BYTE_W;
  localparam int IDX_W         = $clog2(BYTES_PER_ROW);

  logic              rst_i_n;
  logic              row_fetch;
  logic              rd_req;
  logic [IDX_W-1:0]  rd_idx;
  logic              load;
  logic              row_end;
  logic              active;
  logic              show_fg;
  logic [ADDR_W-1:0] row_addr;

  prs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  prs_hseq #(
    .ACTIVE_PIX (ACTIVE_PIX),
    .BYTE_W     (BYTE_W)
  ) u_h (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .pix_en     (pix_en),
    .line_start (line_start),
    .row_fetch  (row_fetch),
    .rd_req     (rd_req),
    .rd_idx     (rd_idx),
    .load_o     (load),
    .row_end_o  (row_end),
    .active_o   (active)
  );

  prs_vseq #(
    .ADDR_W        (ADDR_W),
    .BYTES_PER_ROW (BYTES_PER_ROW),
    .ROWS_PER_LINE (ROWS_PER_LINE),
    .NUM_LINES     (NUM_LINES),
    .GAP_ROWS      (GAP_ROWS),
    .BASE_RST      (BASE_RST)
  ) u_v (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .frame_start (frame_start),
    .row_end     (row_end),
    .base_we     (base_we),
    .base_wdata  (base_wdata),
    .row_addr_o  (row_addr),
    .row_fetch_o (row_fetch)
  );

  prs_shifter #(
    .BYTE_W (BYTE_W)
  ) u_s (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .pix_en     (pix_en),
    .line_start (line_start),
    .active     (active),
    .load       (load),
    .row_fetch  (row_fetch),
    .mem_data   (mem_data),
    .show_fg    (show_fg)
  );

  assign mem_rd   = rd_req;
  assign mem_addr = row_addr + ADDR_W'(rd_idx);
  assign pix_out  = show_fg ? fg_color : bg_color;

  // R11: reads only happen in enabled pixel cycles
  p_rd_on_en_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_rd |-> pix_en);

  // R6: spacing rows and the finished frame issue no reads
  p_no_rd_blank_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !row_fetch |-> !mem_rd);
endmodule

// File: tb/sim_packed_row_scanner.sv
`timescale 1ns/1ps
module sim_packed_row_scanner;
  localparam int RPL = 7;
  localparam int NL  = 7;
  localparam int GAP = 1;
  localparam int PIX = 128;
  localparam int BPR = 16;
  localparam int NROWS = NL * (RPL + GAP) + 2;

  // stimulus vectors: {pix_en spacing, base (-1 = keep reset default), fg, bg}
  localparam int NVEC = 3;
  localparam int VEC [NVEC][4] = '{
    '{1, -1,        5, 2},
    '{2, 'h0100,    9, 0},
    '{3, 'hFFD0,   15, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        line_start = 1'b0;
  logic        frame_start = 1'b0;
  logic        base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic [3:0]  fg_color = 4'h5;
  logic [3:0]  bg_color = 4'h2;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic [3:0]  pix_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  packed_row_scanner u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .line_start  (line_start),
    .frame_start (frame_start),
    .base_we     (base_we),
    .base_wdata  (base_wdata),
    .fg_color    (fg_color),
    .bg_color    (bg_color),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .pix_out     (pix_out)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_data <= pat(mem_addr);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic write_base(input logic [15:0] b);
    @(negedge clk) begin base_we = 1'b1; base_wdata = b; end
    @(negedge clk) base_we = 1'b0;
  endtask

  // scan one raster row; v = raster row index since frame_start
  task automatic scan_row(input int v, input logic [15:0] base, input int sp,
                          input string who);
    int per, ln, r;
    bit vis;
    logic [15:0] rowa;
    int rd_bad, rd_first_act, rd_first_exp, nrd, pix_bad, pix_act, pix_exp;
    int hold_bad, off_rd;
    per = RPL + GAP;
    ln  = v / per;
    r   = v % per;
    vis = (ln < NL) && (r < RPL);
    rowa = base + 16'(BPR * (ln * RPL + r));
    rd_bad = 0; rd_first_act = 0; rd_first_exp = 0; nrd = 0;
    pix_bad = 0; pix_act = 0; pix_exp = 0; hold_bad = 0; off_rd = 0;
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
    for (int k = 1; k <= PIX + 3; k++) begin
      bit er;
      logic [15:0] ea;
      logic [3:0] ep;
      er = vis && ((k == 1) || (k >= 9 && k <= PIX - 7 && ((k - 1) % 8) == 0));
      ea = rowa + 16'((k == 1) ? 0 : (k - 1) / 8);
      pix_en = 1'b1;
      #1;
      if (mem_rd) nrd++;
      if ((mem_rd !== er) || (er && mem_addr !== ea)) begin
        if (rd_bad == 0) begin
          rd_first_act = {mem_rd, mem_addr};
          rd_first_exp = {er, ea};
        end
        rd_bad++;
      end
      @(negedge clk) pix_en = 1'b0;
      ep = bg_color;
      if (vis && k >= 2 && k <= PIX + 1) begin
        int p;
        logic [7:0] d;
        p = k - 2;
        d = pat(rowa + 16'(p / 8));
        ep = d[7 - (p % 8)] ? fg_color : bg_color;
      end
      if (pix_out !== ep) begin
        if (pix_bad == 0) begin pix_act = pix_out; pix_exp = ep; end
        pix_bad++;
      end
      for (int s = 1; s < sp; s++) begin
        @(negedge clk);
        if (mem_rd) off_rd++;
        if (pix_out !== ep) hold_bad++;
      end
    end
    if (vis) begin
      check(rd_bad == 0, $sformatf("R4/R5 %s row %0d read addr/timing", who, v),
            rd_first_act, rd_first_exp);
      check(nrd == BPR, $sformatf("R4 %s row %0d read count", who, v), nrd, BPR);
      check(pix_bad == 0, $sformatf("R2/R3/R8 %s row %0d pixels", who, v),
            pix_act, pix_exp);
    end else if (ln < NL) begin
      check(nrd == 0 && rd_bad == 0, $sformatf("R6 %s gap row %0d no reads", who, v),
            nrd, 0);
      check(pix_bad == 0, $sformatf("R6 %s gap row %0d background", who, v),
            pix_act, pix_exp);
    end else begin
      check(nrd == 0 && rd_bad == 0, $sformatf("R7 %s row %0d after last line", who, v),
            nrd, 0);
      check(pix_bad == 0, $sformatf("R7 %s row %0d background", who, v),
            pix_act, pix_exp);
    end
    if (sp > 1) begin
      check(off_rd == 0, $sformatf("R11 %s row %0d read without enable", who, v),
            off_rd, 0);
      check(hold_bad == 0, $sformatf("R2 %s row %0d pixel hold", who, v),
            hold_bad, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1-scope run hung actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] cur_base;
    int bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pix_out === bg_color && mem_rd === 1'b0, "R1 reset outputs", pix_out, bg_color);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pix_out === bg_color, "R1 after release background", pix_out, bg_color);

    // R8: enables with no row strobe make no reads and stay background
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      pix_en = 1'b1;
      #1;
      if (mem_rd !== 1'b0) bad++;
      @(negedge clk) pix_en = 1'b0;
      if (pix_out !== bg_color) bad++;
    end
    check(bad == 0, "R8 idle enables", bad, 0);

    // table-driven frames
    cur_base = 16'h0C2F;
    for (int i = 0; i < NVEC; i++) begin
      fg_color = 4'(VEC[i][2]);
      bg_color = 4'(VEC[i][3]);
      if (VEC[i][1] >= 0) begin
        cur_base = 16'(VEC[i][1]);
        write_base(cur_base);
      end
      pulse_frame();
      for (int v = 0; v < NROWS; v++) begin
        scan_row(v, cur_base, VEC[i][0], $sformatf("vec%0d", i));
      end
    end

    // R9: base write mid-frame waits for the next frame strobe
    pulse_frame();
    scan_row(0, cur_base, 1, "R9 before write");
    write_base(16'h0400);
    scan_row(1, cur_base, 1, "R9 old base kept");
    scan_row(2, cur_base, 1, "R9 old base kept");
    // R10: frame strobe mid-frame restarts at row 0 with the new base
    pulse_frame();
    cur_base = 16'h0400;
    scan_row(0, cur_base, 1, "R10 restart");
    scan_row(1, cur_base, 2, "R10 restart");

    // R3: colour swap shows the opposite mapping immediately
    fg_color = 4'h2;
    bg_color = 4'hD;
    scan_row(2, cur_base, 1, "R3 swapped colours");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule